// File: doc/BRIEF.md
# Prioritized Bus Interrupt Requester with Acknowledge Daisy Chain

This block lets a board ask the system bus for service on one of seven prioritized, active-low request lines, and then take part in the acknowledge chain that follows. Three level-select switch inputs choose the request level directly as a binary code, because an open switch reads 1 and a closed switch reads 0. The code 0 means no level is chosen, and the board never requests.

Single-cycle event pulses from the board set a pending flag, which software can read back. The request line is driven only while the flag is set, the interrupt-enable bit is on and a level is chosen. When the acknowledge input of the chain falls, the block compares the level on the acknowledged address bits with its own level. If they match and its request is active, it claims the cycle: it drives the programmed 8-bit vector with a data acknowledge and clears the pending flag and the request. If they do not match, it passes the acknowledge down the chain. Both responses stay until the acknowledge input rises again, and they drop in the same instant that it rises.

Top module: `irq_daisy_intr`

## Requirements
- R1: During and right after reset, all request lines are high, the chain output and data acknowledge are high, the vector enable is low and the pending flag reads 0.
- R2: An event pulse sampled at a clock edge makes the pending flag read 1 after that edge, whatever the enable and level settings are.
- R3: After each edge, request line k (bit k-1 of `irq_n_o`) is low exactly when three conditions held at that edge: the pending flag was set, enable was high and the level code was k. No other line is ever low.
- R4: A level code of 0 keeps every request line high, and any acknowledge is passed down the chain.
- R5: With enable low, the pending flag is kept but no line is driven. Raising enable drives the line after the next edge.
- R6: A claim happens when the acknowledge input is sampled low while idle, the acknowledged level matches the registered level and a request is active. After that edge, data acknowledge is low, vector enable is high and `vec_o` holds the vector sampled at that edge. The vector stays stable while the claim lasts.
- R7: A claim clears the pending flag and the request at the same edge, unless an event pulse arrives at that same edge. In that case the flag stays set.
- R8: An acknowledge that is not claimed drives the chain output low after the sampling edge. It leaves the pending flag as it was, and it never coincides with a data acknowledge.
- R9: The chain output, data acknowledge and vector enable are released combinationally as soon as the acknowledge input goes high.
- R10: Once the block has answered, it keeps that answer for as long as the acknowledge input stays low. It does not re-decide, even if its request or level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_sw_i | input | 3 | Level-select switches, binary level code, 0 = off |
| irq_en_i | input | 1 | Interrupt-enable bit from the register file |
| irq_cond_i | input | 1 | Single-cycle event pulse from the board |
| vec_i | input | 8 | Programmed vector register contents |
| iackin_n_i | input | 1 | Acknowledge chain input, active low |
| ack_lvl_i | input | 3 | Acknowledged level from address bits A1 to A3 |
| irq_n_o | output | 7 | Request lines, bit k-1 = level k, active low |
| iackout_n_o | output | 1 | Acknowledge chain output, active low |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| vec_oe_o | output | 1 | Vector drive enable |
| vec_o | output | 8 | Vector driven on D0 to D7 |
| pend_o | output | 1 | Read-only pending flag |

## Verification
A wrong pending or request register shows up after one edge, as a low line at the wrong index, two low lines, or a flag that does not match the event and claim history. A wrong acknowledge state shows up on the edge that samples the falling acknowledge input: the block claims when it should pass, passes when it should claim, or answers both ways. A missing combinational release shows up within the same cycle as the rising acknowledge input. A claim that fails to clear leaves the flag and the line set, and the next mismatching acknowledge exposes it.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_CLAIM = 2'd1,
        ACK_PASS  = 2'd2
    } ack_state_e;
endpackage

// File: rtl/irq_level_decode.sv
// Turns the registered level code into active-low request lines.
module irq_level_decode #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = 3
) (
    input  logic [LVL_W-1:0]   lvl_i,
    input  logic               active_i,
    output logic [NUM_LVL-1:0] line_n_o
);
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
        localparam logic [LVL_W-1:0] CODE = LVL_W'(g + 1);
        assign line_n_o[g] = ~(active_i && (lvl_i == CODE));
    end
endmodule

// File: rtl/iack_responder.sv
// Acknowledge chain decision: claim or pass, held until the input rises.
module iack_responder
    import irq_daisy_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iackin_n_i,
    input  logic [LVL_W-1:0] ack_lvl_i,
    input  logic [LVL_W-1:0] own_lvl_i,
    input  logic             req_i,
    output logic             claim_o,
    output logic             claimed_o,
    output logic             passing_o
);
    typedef struct packed {
        ack_state_e st;
    } resp_t;

    resp_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        claim_o = 1'b0;
        if (iackin_n_i) begin
            s_d.st = ACK_IDLE;
        end else if (s_q.st == ACK_IDLE) begin
            if (req_i && (ack_lvl_i == own_lvl_i)) begin
                s_d.st  = ACK_CLAIM;
                claim_o = 1'b1;
            end else begin
                s_d.st = ACK_PASS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ACK_IDLE};
        else        s_q <= s_d;
    end

    assign claimed_o = (s_q.st == ACK_CLAIM) && !iackin_n_i;
    assign passing_o = (s_q.st == ACK_PASS)  && !iackin_n_i;
endmodule

// File: rtl/irq_daisy_intr.sv
module irq_daisy_intr #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = 3,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   lvl_sw_i,
    input  logic               irq_en_i,
    input  logic               irq_cond_i,
    input  logic [VEC_W-1:0]   vec_i,
    input  logic               iackin_n_i,
    input  logic [LVL_W-1:0]   ack_lvl_i,
    output logic [NUM_LVL-1:0] irq_n_o,
    output logic               iackout_n_o,
    output logic               dtack_n_o,
    output logic               vec_oe_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               pend_o
);
    typedef struct packed {
        logic             pend;
        logic             req;
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } core_t;

    core_t c_d, c_q;
    logic  claim, claimed, passing;

    iack_responder #(.LVL_W(LVL_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .iackin_n_i (iackin_n_i),
        .ack_lvl_i  (ack_lvl_i),
        .own_lvl_i  (c_q.lvl),
        .req_i      (c_q.req),
        .claim_o    (claim),
        .claimed_o  (claimed),
        .passing_o  (passing)
    );

    irq_level_decode #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_dec (
        .lvl_i    (c_q.lvl),
        .active_i (c_q.req),
        .line_n_o (irq_n_o)
    );

    always_comb begin
        c_d      = c_q;
        c_d.lvl  = lvl_sw_i;
        c_d.pend = irq_cond_i | (c_q.pend & ~claim);
        c_d.req  = c_d.pend & irq_en_i & (lvl_sw_i != '0);
        if (claim) c_d.vec = vec_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign iackout_n_o = ~passing;
    assign dtack_n_o   = ~claimed;
    assign vec_oe_o    = claimed;
    assign vec_o       = c_q.vec;
    assign pend_o      = c_q.pend;
endmodule

// File: rtl/irq_daisy_intr_chk.sv
module irq_daisy_intr_chk #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = 3,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LVL_W-1:0]   lvl_sw_i,
    input logic               irq_en_i,
    input logic               irq_cond_i,
    input logic [VEC_W-1:0]   vec_i,
    input logic               iackin_n_i,
    input logic [LVL_W-1:0]   ack_lvl_i,
    input logic [NUM_LVL-1:0] irq_n_o,
    input logic               iackout_n_o,
    input logic               dtack_n_o,
    input logic               vec_oe_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic               pend_o
);
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n_o) <= 1); // R3
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cond_i |=> pend_o); // R2
    AST_LVL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sw_i == '0) |=> (&irq_n_o)); // R4
    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> (&irq_n_o)); // R5
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n_o && $past(!dtack_n_o)) |-> $stable(vec_o)); // R6
    AST_CLAIM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n_o) |-> (!pend_o || $past(irq_cond_i))); // R7
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!iackout_n_o && !dtack_n_o)); // R8
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        iackin_n_i |-> (iackout_n_o && dtack_n_o && !vec_oe_o)); // R9
endmodule

bind irq_daisy_intr irq_daisy_intr_chk #(
    .NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .VEC_W(VEC_W)
) u_chk (.*);

// File: tb/irq_daisy_intr_bench.sv
module irq_daisy_intr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] lvl_sw = 3'd0;
    logic       en = 1'b0, ev = 1'b0;
    logic [7:0] vec = 8'h00;
    logic       iackin_n = 1'b1;
    logic [2:0] ack_lvl = 3'd0;
    logic [6:0] irq_n;
    logic       iackout_n, dtack_n, vec_oe, pend;
    logic [7:0] vec_out;

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R3";

    // reference state: st 0 idle, 1 claimed, 2 passed
    bit       m_pend = 0, m_req = 0;
    bit [2:0] m_lvl = 0;
    bit [7:0] m_vec = 0;
    int       m_st = 0;

    always #5 clk = ~clk;

    irq_daisy_intr u_irq_daisy_intr (
        .clk(clk), .rst_n(rst_n), .lvl_sw_i(lvl_sw), .irq_en_i(en),
        .irq_cond_i(ev), .vec_i(vec), .iackin_n_i(iackin_n), .ack_lvl_i(ack_lvl),
        .irq_n_o(irq_n), .iackout_n_o(iackout_n), .dtack_n_o(dtack_n),
        .vec_oe_o(vec_oe), .vec_o(vec_out), .pend_o(pend)
    );

    function automatic logic [6:0] exp_lines(bit r, bit [2:0] l);
        logic [6:0] v = 7'h7f;
        for (int k = 0; k < 7; k++) if (r && l == 3'(k + 1)) v[k] = 1'b0;
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R3", 32'(irq_n), 32'(exp_lines(m_req, m_lvl)));
        chk("R2", 32'(pend), 32'(m_pend));
        chk("R8", 32'(iackout_n), 32'(!(m_st == 2 && !iackin_n)));
        chk("R6", 32'(dtack_n), 32'(!(m_st == 1 && !iackin_n)));
        chk("R9", 32'(vec_oe), 32'(m_st == 1 && !iackin_n));
        if (m_st == 1 && !iackin_n) chk("R6", 32'(vec_out), 32'(m_vec));
    endtask

    task automatic model_edge();
        bit claim = (m_st == 0) && !iackin_n && m_req && (ack_lvl == m_lvl);
        m_pend = ev | (m_pend & !claim);
        m_req  = m_pend && en && (lvl_sw != 0);
        if (claim) m_vec = vec;
        if (iackin_n) m_st = 0;
        else if (m_st == 0) m_st = claim ? 1 : 2;
        m_lvl = lvl_sw;
    endtask

    task automatic step(bit [2:0] l, bit e, bit c, bit ia_n, bit [2:0] al, bit [7:0] v);
        @(negedge clk);
        lvl_sw = l; en = e; ev = c; iackin_n = ia_n; ack_lvl = al; vec = v;
        #1 compare();
        @(posedge clk);
        #1 model_edge();
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        chk("R1", 32'(irq_n), 32'h7f);
        chk("R1", 32'(iackout_n), 1);
        chk("R1", 32'(dtack_n), 1);
        chk("R1", 32'(vec_oe), 0);
        chk("R1", 32'(pend), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 R5: event with enable low keeps pending, no line; enabling drives it
        tag = "R5";
        step(3'd4, 0, 1, 1, 0, 8'h00);
        step(3'd4, 0, 0, 1, 0, 8'h00);
        step(3'd4, 1, 0, 1, 0, 8'h00);
        step(3'd4, 1, 0, 1, 0, 8'h00);
        // R8: mismatched acknowledge passes, pending unchanged
        tag = "R8";
        step(3'd4, 1, 0, 0, 3'd2, 8'h00);
        step(3'd4, 1, 0, 0, 3'd4, 8'h00);
        // R10: answer held although the level now matches
        tag = "R10";
        step(3'd4, 1, 0, 0, 3'd4, 8'h00);
        // R9: release on rising acknowledge
        tag = "R9";
        step(3'd4, 1, 0, 1, 3'd4, 8'h00);
        // R6 R7: matching acknowledge claims and clears
        tag = "R6";
        step(3'd4, 1, 0, 0, 3'd4, 8'hA5);
        step(3'd4, 1, 0, 0, 3'd4, 8'h3C);
        step(3'd4, 1, 0, 1, 3'd4, 8'h3C);
        // R7: event at the claim edge keeps pending
        tag = "R7";
        step(3'd7, 1, 1, 1, 3'd7, 8'h00);
        step(3'd7, 1, 1, 0, 3'd7, 8'h81);
        step(3'd7, 1, 0, 0, 3'd7, 8'h00);
        step(3'd7, 1, 0, 1, 3'd7, 8'h00);
        // R4: level code 0 never requests, acknowledge passed
        tag = "R4";
        step(3'd0, 1, 1, 1, 3'd0, 8'h00);
        step(3'd0, 1, 0, 0, 3'd0, 8'h00);
        step(3'd0, 1, 0, 0, 3'd0, 8'h00);
        step(3'd0, 1, 0, 1, 3'd0, 8'h00);
        step(3'd1, 1, 0, 1, 3'd0, 8'h00);
        step(3'd1, 1, 0, 1, 3'd0, 8'h00);

        tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            bit [2:0] l  = ($urandom % 8 == 0) ? 3'd0 : 3'(1 + $urandom % 7);
            bit       e  = ($urandom % 5) != 0;
            bit       c  = ($urandom % 6) == 0;
            bit       ia = ($urandom % 3) != 0;
            bit [2:0] al = ($urandom % 2) ? l : 3'($urandom);
            step(l, e, c, ia, al, 8'($urandom));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule